// File: doc/BRIEF.md
# Queue-Fed Pulse-Width Modulator

This block generates a pulse-width modulated waveform. The duty value for each period comes from a small sample queue. A clock-source selector picks one of three single-cycle tick inputs, or none. A prescaler then divides the chosen tick by a programmable ratio. Each divided tick advances a 16-bit up-counter that wraps after a programmed terminal value. Every queued sample stays in effect for 1, 2, 4 or 8 counter periods. After that, the next queued sample takes over at a wrap. When the queue is empty at that moment, the current sample stays in effect.

Samples arrive on a valid/ready stream. A sample is accepted on any clock edge where `smp_valid` and `smp_ready` are both high. The producer must hold `smp_valid` and `smp_data` steady until acceptance. `smp_ready` is low while the queue holds its full depth or while soft reset is held. Pushing does not depend on the enable bit, so software can preload samples before starting.

A two-bit mode picks the polarity of the output, or disconnects the output. Wrap and match events set sticky flags. Each flag is cleared by a one-cycle clear pulse, and each has its own interrupt enable.

Top module: `sample_pwm`

## Requirements
- R1: After reset or a soft-reset cycle the following hold: `count_value` is 0, both flags are 0, the queue is empty and the output phase is the low phase. With mode 00, `pwm_out` reads 0.
- R2: A clock-select code of 00 stops all counting. Codes 01, 10 and 11 select `tick_main`, `tick_fast` and `tick_slow`, and an unselected tick has no effect.
- R3: With prescale value N, the counter advances once per N+1 selected ticks. The first advance comes on the (N+1)-th tick after a soft reset.
- R4: The counter steps from 0 up to `cfg_period`. On the next advance it returns to 0, which is the wrap event. A count at or above a newly lowered period also wraps.
- R5: A match event occurs on an advance whose new count equals the sample in effect after that advance. As a result, sample S gives S high cycles per period of period+1 advances. Sample 0 gives no high time, and a sample above the period gives a constant high level.
- R6: Repeat codes 00, 01, 10 and 11 keep each sample for 1, 2, 4 and 8 periods. The next queued sample is taken at the wrap that ends the last of those periods.
- R7: If the queue is empty when a new sample is due, the current sample is kept. The block tries again at every following wrap.
- R8: Output mode 00 gives a high phase from a wrap until a match, and mode 01 inverts this. When a wrap and a match occur together, the match decides the phase. Modes 10 and 11 force `pwm_out` and `pwm_out_en` to 0.
- R9: Each event flag is set by its event and stays set until its clear pulse. A set and a clear in the same cycle leave the flag set.
- R10: `irq` is high exactly when some flag is set while its enable is high.
- R11: The queue holds up to 4 samples and releases them in arrival order. `smp_ready` is low when the queue is full or soft reset is held.
- R12: While `cfg_enable` is 0, the counter and prescaler hold their values. While `cfg_soft_reset` is 1, the counter, prescaler, queue, sample, phase and flags are all held at their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Run control; 0 freezes the counter |
| cfg_soft_reset | input | 1 | Holds the block in its reset state while 1 |
| cfg_clk_sel | input | 2 | 00 off, 01 main, 10 fast, 11 slow tick |
| cfg_prescale | input | 12 | Divide ratio minus one |
| cfg_repeat | input | 2 | Periods per sample: 1, 2, 4, 8 |
| cfg_out_mode | input | 2 | 00 high after wrap, 01 low after wrap, 1x disconnected |
| cfg_period | input | 16 | Terminal count |
| tick_main | input | 1 | Main tick enable |
| tick_fast | input | 1 | Fast tick enable |
| tick_slow | input | 1 | Slow tick enable |
| smp_valid | input | 1 | Sample stream valid |
| smp_data | input | 16 | Sample (duty) value |
| smp_ready | output | 1 | Sample stream ready |
| count_value | output | 16 | Current count |
| flag_clr_wrap | input | 1 | Clear pulse for the wrap flag |
| flag_clr_match | input | 1 | Clear pulse for the match flag |
| irq_en_wrap | input | 1 | Interrupt enable for the wrap flag |
| irq_en_match | input | 1 | Interrupt enable for the match flag |
| flag_wrap | output | 1 | Sticky wrap flag |
| flag_match | output | 1 | Sticky match flag |
| irq | output | 1 | Interrupt request |
| pwm_out | output | 1 | Modulated output |
| pwm_out_en | output | 1 | Output drive enable |

## Verification
A stale prescaler phase shows up on `count_value` within N+1 selected ticks, as an early or late advance. A wrong active sample or a wrong repeat count changes the cycle on which `pwm_out` falls within the first affected period. A corrupted queue pointer or occupancy shows up at the next sample load as an out-of-order duty, or at once as a wrong `smp_ready` level. A flag or phase bit in the wrong state is visible on `flag_wrap`, `flag_match`, `irq` or `pwm_out` on the very next clock edge.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

  typedef enum logic [1:0] {
    CS_OFF  = 2'b00,
    CS_MAIN = 2'b01,
    CS_FAST = 2'b10,
    CS_SLOW = 2'b11
  } clk_sel_e;

  typedef enum logic [1:0] {
    OM_HIGH_AT_WRAP = 2'b00,
    OM_LOW_AT_WRAP  = 2'b01,
    OM_DETACH_A     = 2'b10,
    OM_DETACH_B     = 2'b11
  } out_mode_e;

  localparam int NUM_EVENTS = 2;
  localparam int EV_WRAP    = 0;
  localparam int EV_MATCH   = 1;

  // Periods a sample stays in effect for a repeat code.
  function automatic logic [3:0] periods_per_sample(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

endpackage

// File: rtl/spwm_tick_gen.sv
module spwm_tick_gen #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [1:0]       sel,
  input  logic             tick_main,
  input  logic             tick_fast,
  input  logic             tick_slow,
  input  logic [PRE_W-1:0] div,
  output logic             step
);
  import spwm_pkg::*;

  logic             src_tick;
  logic [PRE_W-1:0] pre_q;
  logic             pre_last;

  always_comb begin
    unique case (clk_sel_e'(sel))
      CS_MAIN: src_tick = tick_main;
      CS_FAST: src_tick = tick_fast;
      CS_SLOW: src_tick = tick_slow;
      default: src_tick = 1'b0;
    endcase
  end

  // Greater-or-equal lets a lowered ratio take effect without a long run-out.
  assign pre_last = (pre_q >= div);
  assign step     = run & src_tick & pre_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (clear) begin
      pre_q <= '0;
    end else if (run && src_tick) begin
      pre_q <= pre_last ? '0 : pre_q + 1'b1;
    end
  end

  a_r2_off_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == CS_OFF) |-> !step);

  a_r3_step_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (step && div != '0) |=> (!step || div == '0));

endmodule

// File: rtl/spwm_sample_fifo.sv
module spwm_sample_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  input  logic         pop,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push, take;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  assign in_ready  = !flush && (cnt_q < FULL_CNT);
  assign out_valid = (cnt_q != '0);
  assign out_data  = mem[rd_q];
  assign push      = in_valid && in_ready;
  assign take      = pop && out_valid;

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (take) rd_q <= bump(rd_q);
      case ({push, take})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  a_r11_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flush) |-> (cnt_q != '0));

endmodule

// File: rtl/spwm_period_engine.sv
module spwm_period_engine #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] period,
  input  logic [1:0]       rep_code,
  input  logic             q_valid,
  input  logic [CNT_W-1:0] q_data,
  output logic             q_pop,
  output logic [CNT_W-1:0] count,
  output logic             ev_wrap,
  output logic             ev_match,
  output logic             phase_hi
);
  import spwm_pkg::*;

  logic [CNT_W-1:0] cnt_q, act_q, cnt_next, act_next;
  logic [2:0]       rep_q;
  logic             phase_q;
  logic             at_end, load_due;

  assign at_end   = (cnt_q >= period);
  assign load_due = at_end && (rep_q == '0);
  assign q_pop    = step && load_due && q_valid;
  assign act_next = q_pop ? q_data : act_q;
  assign cnt_next = at_end ? '0 : cnt_q + 1'b1;
  assign ev_wrap  = step && at_end;
  assign ev_match = step && (cnt_next == act_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      act_q   <= '0;
      rep_q   <= '0;
      phase_q <= 1'b0;
    end else if (clear) begin
      cnt_q   <= '0;
      act_q   <= '0;
      rep_q   <= '0;
      phase_q <= 1'b0;
    end else if (step) begin
      cnt_q <= cnt_next;
      act_q <= act_next;
      if (at_end) begin
        if (rep_q != '0)  rep_q <= rep_q - 1'b1;
        else if (q_valid) rep_q <= 3'(periods_per_sample(rep_code) - 4'd1);
        else              rep_q <= '0;
      end
      if (ev_match)     phase_q <= 1'b0;
      else if (at_end)  phase_q <= 1'b1;
    end
  end

  assign count    = cnt_q;
  assign phase_hi = phase_q;

  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wrap && !clear) |=> (cnt_q == '0));

  a_r12_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable(cnt_q));

  a_r8_match_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_match && !clear) |=> !phase_q);

  a_r7_keep_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (step && load_due && !q_valid && !clear) |=> $stable(act_q));

endmodule

// File: rtl/spwm_event_flags.sv
module spwm_event_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q[i] <= 1'b0;
      else if (clear)  flag_q[i] <= 1'b0;
      else             flag_q[i] <= (flag_q[i] & ~clr[i]) | ev[i];
    end

    a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !clr[i] && !clear) |=> flag_q[i]);

    a_r9_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[i] && !clear) |=> flag_q[i]);
  end

  assign flags = flag_q;
  assign irq   = |(flag_q & en);

endmodule

// File: rtl/sample_pwm.sv
module sample_pwm #(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 12,
  parameter int QDEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_soft_reset,
  input  logic [1:0]       cfg_clk_sel,
  input  logic [PRE_W-1:0] cfg_prescale,
  input  logic [1:0]       cfg_repeat,
  input  logic [1:0]       cfg_out_mode,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic             tick_main,
  input  logic             tick_fast,
  input  logic             tick_slow,
  input  logic             smp_valid,
  input  logic [CNT_W-1:0] smp_data,
  output logic             smp_ready,
  output logic [CNT_W-1:0] count_value,
  input  logic             flag_clr_wrap,
  input  logic             flag_clr_match,
  input  logic             irq_en_wrap,
  input  logic             irq_en_match,
  output logic             flag_wrap,
  output logic             flag_match,
  output logic             irq,
  output logic             pwm_out,
  output logic             pwm_out_en
);
  import spwm_pkg::*;

  logic                  run, step;
  logic                  q_valid, q_pop;
  logic [CNT_W-1:0]      q_data;
  logic                  ev_wrap, ev_match, phase_hi;
  logic [NUM_EVENTS-1:0] ev_vec, clr_vec, en_vec, flag_vec;

  assign run = cfg_enable & ~cfg_soft_reset;

  spwm_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (cfg_soft_reset),
    .run       (run),
    .sel       (cfg_clk_sel),
    .tick_main (tick_main),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow),
    .div       (cfg_prescale),
    .step      (step)
  );

  spwm_sample_fifo #(.W(CNT_W), .DEPTH(QDEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (cfg_soft_reset),
    .in_valid  (smp_valid),
    .in_data   (smp_data),
    .in_ready  (smp_ready),
    .pop       (q_pop),
    .out_valid (q_valid),
    .out_data  (q_data)
  );

  spwm_period_engine #(.CNT_W(CNT_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cfg_soft_reset),
    .step     (step),
    .period   (cfg_period),
    .rep_code (cfg_repeat),
    .q_valid  (q_valid),
    .q_data   (q_data),
    .q_pop    (q_pop),
    .count    (count_value),
    .ev_wrap  (ev_wrap),
    .ev_match (ev_match),
    .phase_hi (phase_hi)
  );

  always_comb begin
    ev_vec            = '0;
    clr_vec           = '0;
    en_vec            = '0;
    ev_vec[EV_WRAP]   = ev_wrap;
    ev_vec[EV_MATCH]  = ev_match;
    clr_vec[EV_WRAP]  = flag_clr_wrap;
    clr_vec[EV_MATCH] = flag_clr_match;
    en_vec[EV_WRAP]   = irq_en_wrap;
    en_vec[EV_MATCH]  = irq_en_match;
  end

  spwm_event_flags #(.N(NUM_EVENTS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (cfg_soft_reset),
    .ev    (ev_vec),
    .clr   (clr_vec),
    .en    (en_vec),
    .flags (flag_vec),
    .irq   (irq)
  );

  assign flag_wrap  = flag_vec[EV_WRAP];
  assign flag_match = flag_vec[EV_MATCH];

  always_comb begin
    unique case (out_mode_e'(cfg_out_mode))
      OM_HIGH_AT_WRAP: begin pwm_out = phase_hi;  pwm_out_en = 1'b1; end
      OM_LOW_AT_WRAP:  begin pwm_out = ~phase_hi; pwm_out_en = 1'b1; end
      default:         begin pwm_out = 1'b0;      pwm_out_en = 1'b0; end
    endcase
  end

endmodule

// File: tb/sample_pwm_bench.sv
module sample_pwm_bench;
  localparam int QD = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, en, srst, tm, tf, ts, sv, cr, cc, ier, iec;
  logic [1:0]  sel, rep, mode;
  logic [11:0] presc;
  logic [15:0] per, sd;
  logic        sr, fr, fc, irq, po, poe;
  logic [15:0] cnt_o;

  sample_pwm u_sample_pwm (
    .clk(clk), .rst_n(rst_n), .cfg_enable(en), .cfg_soft_reset(srst),
    .cfg_clk_sel(sel), .cfg_prescale(presc), .cfg_repeat(rep),
    .cfg_out_mode(mode), .cfg_period(per), .tick_main(tm), .tick_fast(tf),
    .tick_slow(ts), .smp_valid(sv), .smp_data(sd), .smp_ready(sr),
    .count_value(cnt_o), .flag_clr_wrap(cr), .flag_clr_match(cc),
    .irq_en_wrap(ier), .irq_en_match(iec), .flag_wrap(fr), .flag_match(fc),
    .irq(irq), .pwm_out(po), .pwm_out_en(poe)
  );

  // Reference model state
  logic [15:0] m_cnt, m_act, m_nc;
  logic [11:0] m_pre;
  logic [15:0] m_q [QD];
  int          m_qc, m_rep;
  logic        m_phase, m_fr, m_fc;
  logic        m_src, m_step, m_wr, m_pop, m_push, m_evr, m_evc;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  function automatic logic pick_tick(input logic [1:0] s, input logic a,
                                     input logic b, input logic c);
    case (s)
      2'b01:   return a;
      2'b10:   return b;
      2'b11:   return c;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n || srst) begin
      m_cnt = '0; m_act = '0; m_pre = '0; m_rep = 0; m_phase = 1'b0;
      m_fr = 1'b0; m_fc = 1'b0; m_qc = 0;
    end else begin
      m_src  = pick_tick(sel, tm, tf, ts);
      m_step = en && m_src && (m_pre >= presc);
      if (en && m_src) m_pre = (m_pre >= presc) ? 12'd0 : m_pre + 12'd1;
      m_push = sv && (m_qc < QD);
      m_pop = 1'b0; m_evr = 1'b0; m_evc = 1'b0;
      if (m_step) begin
        m_wr = (m_cnt >= per);
        m_nc = m_wr ? 16'd0 : m_cnt + 16'd1;
        if (m_wr && m_rep == 0 && m_qc > 0) begin
          m_pop = 1'b1;
          m_act = m_q[0];
        end
        if (m_wr) begin
          if (m_rep != 0)  m_rep = m_rep - 1;
          else if (m_pop)  m_rep = (1 << rep) - 1;
        end
        m_cnt = m_nc;
        m_evr = m_wr;
        m_evc = (m_nc == m_act);
        if (m_evc)      m_phase = 1'b0;
        else if (m_wr)  m_phase = 1'b1;
      end
      m_fr = (m_fr && !cr) || m_evr;
      m_fc = (m_fc && !cc) || m_evc;
      if (m_pop) begin
        for (int i = 0; i < QD - 1; i++) m_q[i] = m_q[i+1];
        m_qc = m_qc - 1;
      end
      if (m_push) begin
        m_q[m_qc] = sd;
        m_qc = m_qc + 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycle();
    logic e_po, e_poe;
    @(negedge clk);
    e_poe = !mode[1];
    e_po  = !mode[1] && (m_phase ^ mode[0]);
    chk("R4 count_value", int'(cnt_o), int'(m_cnt));
    chk("R5 R6 R7 R8 pwm_out", int'(po), int'(e_po));
    chk("R8 pwm_out_en", int'(poe), int'(e_poe));
    chk("R9 flag_wrap", int'(fr), int'(m_fr));
    chk("R9 flag_match", int'(fc), int'(m_fc));
    chk("R10 irq", int'(irq), int'((m_fr && ier) || (m_fc && iec)));
    chk("R11 smp_ready", int'(sr), int'(!srst && m_qc < QD));
  endtask

  task automatic soft_pulse();
    srst = 1'b1;
    cycle();
    srst = 1'b0;
  endtask

  task automatic push_one(input logic [15:0] v);
    sv = 1'b1; sd = v;
    cycle();
    sv = 1'b0;
  endtask

  task automatic duty_window(input string tag, input int exp_hi);
    int hi = 0;
    repeat (20) cycle();
    for (int k = 0; k < 40; k++) begin
      cycle();
      hi += int'(po);
    end
    chk(tag, hi, exp_hi);
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete (all requirements)");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; en = 1'b0; srst = 1'b0; tm = 1'b0; tf = 1'b0; ts = 1'b0;
    sv = 1'b0; cr = 1'b0; cc = 1'b0; ier = 1'b0; iec = 1'b0;
    sel = 2'b00; rep = 2'b00; mode = 2'b00; presc = '0; per = '0; sd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cycle();
    // R1 reset state
    chk("R1 count after reset", int'(cnt_o), 0);
    chk("R1 flags after reset", int'({fr, fc}), 0);
    chk("R1 ready after reset", int'(sr), 1);
    chk("R1 pwm_out after reset", int'(po), 0);

    // R2 clock selection
    en = 1'b1; presc = 12'd0; per = 16'd1000; tm = 1'b1; tf = 1'b0;
    sel = 2'b00;
    repeat (10) cycle();
    chk("R2 select off holds count", int'(cnt_o), 0);
    sel = 2'b10;
    repeat (10) cycle();
    chk("R2 unselected tick ignored", int'(cnt_o), 0);
    tf = 1'b1;
    repeat (5) cycle();
    chk("R2 fast tick counts", int'(cnt_o), 5);

    // R3 prescaler, R12 freeze and soft reset
    sel = 2'b01; presc = 12'd2;
    soft_pulse();
    chk("R12 soft reset clears count", int'(cnt_o), 0);
    repeat (9) cycle();
    chk("R3 divide by three", int'(cnt_o), 3);
    en = 1'b0;
    repeat (10) cycle();
    chk("R12 disabled count holds", int'(cnt_o), 3);
    en = 1'b1;

    // R11 queue fills to depth
    sel = 2'b00;
    soft_pulse();
    sv = 1'b1;
    for (int k = 0; k < 4; k++) begin
      sd = 16'(k + 1);
      cycle();
    end
    chk("R11 ready low when full", int'(sr), 0);
    sv = 1'b0;
    srst = 1'b1;
    cycle();
    chk("R11 ready low in soft reset", int'(sr), 0);
    srst = 1'b0;
    cycle();
    chk("R1 queue flushed, ready", int'(sr), 1);

    // R5 R7 R8 duty measurements, period 3, one step per cycle
    per = 16'd3; presc = 12'd0; sel = 2'b01; tm = 1'b1; rep = 2'b00; mode = 2'b00;
    push_one(16'd1);
    duty_window("R5 R7 sample 1 high cycles", 10);
    mode = 2'b01;
    duty_window("R8 inverted polarity high cycles", 30);
    mode = 2'b00;
    push_one(16'd0);
    duty_window("R5 sample 0 no high time", 0);
    push_one(16'd9);
    duty_window("R5 sample above period constant high", 40);
    mode = 2'b10;
    duty_window("R8 detached output", 0);
    chk("R8 detached enable", int'(poe), 0);
    mode = 2'b00;

    // R9 R10 flags and interrupt
    sel = 2'b00;
    cycle();
    chk("R9 wrap flag sticky", int'(fr), 1);
    ier = 1'b1;
    cycle();
    chk("R10 irq from wrap flag", int'(irq), 1);
    cr = 1'b1;
    cycle();
    cr = 1'b0;
    chk("R9 clear pulse", int'(fr), 0);
    chk("R10 irq drops", int'(irq), int'(fc && iec));

    // R6 repeat and mixed random phases
    for (int ph = 0; ph < 14; ph++) begin
      per   = 16'($urandom_range(0, 12));
      presc = 12'($urandom_range(0, 3));
      sel   = 2'($urandom_range(0, 3));
      if (ph < 4) sel = 2'b01;
      rep   = 2'(ph % 4);
      mode  = 2'($urandom_range(0, 3));
      ier   = 1'($urandom_range(0, 1));
      iec   = 1'($urandom_range(0, 1));
      for (int c = 0; c < 800; c++) begin
        en   = ($urandom_range(0, 39) != 0);
        srst = ($urandom_range(0, 299) == 0);
        tm   = ($urandom_range(0, 2) != 0);
        tf   = 1'($urandom_range(0, 1));
        ts   = ($urandom_range(0, 3) == 0);
        sv   = ($urandom_range(0, 5) == 0);
        sd   = 16'($urandom_range(0, int'(per) + 2));
        cr   = ($urandom_range(0, 15) == 0);
        cc   = ($urandom_range(0, 15) == 0);
        cycle();
      end
    end
    srst = 1'b0; sv = 1'b0; cr = 1'b0; cc = 1'b0;
    cycle();

    done = 1'b1;
    finish_run();
  end

endmodule